// File: doc/BRIEF.md
# Full-Bridge Converter Real-Time Plant Model

This block emulates a full-bridge DC-DC converter feeding an LC output filter and a resistive load. It runs at one integration step per clock, so a controller under test can drive its four switch gates straight into it. On every step it reads the gate states, works out which leg of each half-bridge conducts (a closed switch, or the antiparallel diode when both switches of a half are open), picks the matching inductor voltage, and advances the inductor current and the capacitor voltage by one forward-Euler step. All state is signed two's-complement fixed point, and both states saturate on overflow.

The step constants (step time over inductance, step time over capacitance, and the reciprocal of the load resistance) are computed outside the block and applied as unsigned inputs with `CF` fractional bits. The supply voltage and both states share one signed format. The block is a closed feedback loop with nothing to buffer, so it has no valid/ready handshake: it takes every input on every clock, and it cannot stall. A plain `alt_step` pin selects a two-cycle mode. In that mode, the next state is registered on one cycle and committed on the following cycle, which allows a shorter logic path.

Top module: `fbridge_plant`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `il`, `vo` and the internal step phase to zero. The first edge after `rst` falls is a phase-0 edge.
- R2: The left bit d is 1 when `sw[0]` (upper-left switch) is on. It is also 1 when `sw[0]` and `sw[2]` (lower-left switch) are both off and `il` is negative. Otherwise d is 0.
- R3: The right bit q is 1 when `sw[1]` is on. It is also 1 when `sw[1]` and `sw[3]` are both off and `il` is strictly positive. Otherwise q is 0.
- R4: When {d,q} = 2'b10, the inductor voltage is vL = `vg` − `vo`.
- R5: When {d,q} = 2'b01, the inductor voltage is vL = −`vg` − `vo`.
- R6: When {d,q} = 2'b00 or 2'b11, the inductor voltage is vL = −`vo`.
- R7: The next `il` is `il` + ((vL·`k_il`) >>> `CF`), with an arithmetic (floor) shift.
- R8: The next `vo` is `vo` + (((`il` − iR)·`k_vo`) >>> `CF`), where iR = (`vo`·`k_ld`) >>> `CF`. Both updates use the values of `il` and `vo` from before the edge.
- R9: Each next state saturates to the `W`-bit signed range [−2^(W−1), 2^(W−1)−1].
- R10: The phase toggles on every edge after reset. On a phase-0 edge, the next states computed from the present inputs are captured. If `alt_step` is 1 on a phase-0 edge, `il` and `vo` hold. If `alt_step` is 1 on a phase-1 edge, they take the captured values. If `alt_step` is 0, the states update on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; one integration step per edge |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | 4 | Gate states: [0] upper-left, [1] upper-right, [2] lower-left, [3] lower-right |
| vg | input | W | Supply voltage, signed, state format |
| k_il | input | KW | Step time over inductance, unsigned, CF fraction bits |
| k_vo | input | KW | Step time over capacitance, unsigned, CF fraction bits |
| k_ld | input | KW | Reciprocal of load resistance, unsigned, CF fraction bits |
| alt_step | input | 1 | 1 selects the two-cycle update mode |
| il | output | W | Inductor current state, signed |
| vo | output | W | Output (capacitor) voltage state, signed |

## Verification
The bench drives a new random gate pattern on every step for thousands of steps. This lets the inductor current swing through both signs, so every d,q combination occurs, and so do both diode-conduction cases. Each step's result is compared exactly with an arithmetic model. A failure is tagged with the rule that governed that step, which separates an error in the switch path from an error in the diode-conduction path. The same random stream is then run in the two-cycle mode to show the hold-then-commit pattern. Directed runs with a large current constant and a fixed gate pair drive the current into its positive rail and then its negative rail, which tests saturation in each direction. A reset in the middle of a run shows that the phase restarts.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  // Conducting-branch code {d,q}; d = left half, q = right half.
  typedef enum logic [1:0] {
    CFG_OPEN  = 2'b00,
    CFG_NEG   = 2'b01,
    CFG_POS   = 2'b10,
    CFG_SHORT = 2'b11
  } bridge_cfg_e;
endpackage

// File: rtl/fbp_branch_sel.sv
module fbp_branch_sel
  import fbp_pkg::*;
(
  input  logic [3:0]  sw,
  input  logic        il_neg,
  input  logic        il_pos,
  output bridge_cfg_e cfg
);
  logic d_bit, q_bit;

  // Left half: upper switch, or upper diode when the half is open and current is negative.
  always_comb begin
    d_bit = sw[0] | (~sw[0] & ~sw[2] & il_neg);
    q_bit = sw[1] | (~sw[1] & ~sw[3] & il_pos);
    cfg   = bridge_cfg_e'({d_bit, q_bit});
  end
endmodule

// File: rtl/fbp_euler_step.sv
module fbp_euler_step #(
  parameter int W  = 32,
  parameter int RW = 34,
  parameter int KW = 18,
  parameter int CF = 16
) (
  input  logic signed [W-1:0]  x,
  input  logic signed [RW-1:0] rate,
  input  logic        [KW-1:0] k,
  output logic signed [W-1:0]  x_nx
);
  localparam int MW = RW + KW + 1;
  localparam int PW = MW + 1;
  localparam logic signed [PW-1:0] XMAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] XMIN = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [MW-1:0] rate_x, k_x, prod, inc;
  logic signed [PW-1:0] sum;

  always_comb begin
    rate_x = MW'(rate);
    k_x    = MW'($signed({1'b0, k}));
    prod   = rate_x * k_x;
    inc    = prod >>> CF;
    sum    = PW'(x) + PW'(inc);
    if (sum > XMAX)      x_nx = XMAX[W-1:0];
    else if (sum < XMIN) x_nx = XMIN[W-1:0];
    else                 x_nx = sum[W-1:0];
  end
endmodule

// File: rtl/fbridge_plant.sv
module fbridge_plant
  import fbp_pkg::*;
#(
  parameter int W  = 32,
  parameter int KW = 18,
  parameter int CF = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          sw,
  input  logic signed [W-1:0] vg,
  input  logic [KW-1:0]       k_il,
  input  logic [KW-1:0]       k_vo,
  input  logic [KW-1:0]       k_ld,
  input  logic                alt_step,
  output logic signed [W-1:0] il,
  output logic signed [W-1:0] vo
);
  localparam int VLW = W + 2;
  localparam int IRW = W + KW + 1;
  localparam int ICW = IRW + 1;

  logic signed [W-1:0]   il_q, vo_q, il_c, vo_c, il_nx, vo_nx;
  logic                  phase;
  bridge_cfg_e           cfg;
  logic signed [VLW-1:0] vl;
  logic signed [IRW-1:0] vo_e, kr_e, ir_full, ir;
  logic signed [ICW-1:0] ic;

  fbp_branch_sel u_sel (
    .sw     (sw),
    .il_neg (il_q[W-1]),
    .il_pos (~il_q[W-1] & (|il_q)),
    .cfg    (cfg)
  );

  always_comb begin
    unique case (cfg)
      CFG_POS: vl = VLW'(vg) - VLW'(vo_q);
      CFG_NEG: vl = -VLW'(vg) - VLW'(vo_q);
      default: vl = -VLW'(vo_q);
    endcase
    vo_e    = IRW'(vo_q);
    kr_e    = IRW'($signed({1'b0, k_ld}));
    ir_full = vo_e * kr_e;
    ir      = ir_full >>> CF;
    ic      = ICW'(il_q) - ICW'(ir);
  end

  fbp_euler_step #(.W(W), .RW(VLW), .KW(KW), .CF(CF)) u_il_step (
    .x(il_q), .rate(vl), .k(k_il), .x_nx(il_nx)
  );

  fbp_euler_step #(.W(W), .RW(ICW), .KW(KW), .CF(CF)) u_vo_step (
    .x(vo_q), .rate(ic), .k(k_vo), .x_nx(vo_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      il_q  <= '0;
      vo_q  <= '0;
      il_c  <= '0;
      vo_c  <= '0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        il_c <= il_nx;
        vo_c <= vo_nx;
        if (!alt_step) begin
          il_q <= il_nx;
          vo_q <= vo_nx;
        end
      end else if (alt_step) begin
        il_q <= il_c;
        vo_q <= vo_c;
      end else begin
        il_q <= il_nx;
        vo_q <= vo_nx;
      end
    end
  end

  assign il = il_q;
  assign vo = vo_q;
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                alt_step,
  input logic                phase,
  input logic [1:0]          cfg,
  input logic signed [W-1:0] vg,
  input logic signed [W-1:0] il,
  input logic signed [W-1:0] vo
);
  // R1: reset clears both states and the phase
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (il == '0 && vo == '0 && !phase));

  // R10: a phase-0 edge in two-cycle mode leaves the states untouched
  a_r10_hold_even: assert property (@(posedge clk) disable iff (rst)
    (alt_step && !phase) |=> ($stable(il) && $stable(vo)));

  // R6: freewheeling with non-negative voltage cannot raise the current
  a_r6_free_no_rise: assert property (@(posedge clk) disable iff (rst)
    (!alt_step && (cfg == 2'b00 || cfg == 2'b11) && vo > 0) |=> (il <= $past(il)));

  // R4: driving forward with supply above output cannot lower the current
  a_r4_drive_no_fall: assert property (@(posedge clk) disable iff (rst)
    (!alt_step && cfg == 2'b10 && vg > vo) |=> (il >= $past(il)));
endmodule

bind fbridge_plant fbp_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .alt_step(alt_step), .phase(phase),
  .cfg(cfg), .vg(vg), .il(il_q), .vo(vo_q)
);

// File: tb/sim_fbridge_plant.sv
`timescale 1ns/1ps
module sim_fbridge_plant;
  localparam int W  = 32;
  localparam int KW = 18;
  localparam int CF = 16;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [3:0]          sw = '0;
  logic signed [W-1:0] vg = '0;
  logic [KW-1:0]       k_il = '0, k_vo = '0, k_ld = '0;
  logic                alt_step = 1'b0;
  logic signed [W-1:0] il, vo;

  int n_chk = 0;
  int n_bad = 0;

  longint m_il, m_vo, m_cil, m_cvo;
  bit     m_ph;
  string  il_tag;

  fbridge_plant #(.W(W), .KW(KW), .CF(CF)) u0 (
    .clk(clk), .rst(rst), .sw(sw), .vg(vg), .k_il(k_il), .k_vo(k_vo),
    .k_ld(k_ld), .alt_step(alt_step), .il(il), .vo(vo)
  );

  always #5 clk = ~clk;

  function automatic longint sat(input longint x);
    if (x > SMAX) return SMAX;
    if (x < SMIN) return SMIN;
    return x;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_il = 0; m_vo = 0; m_cil = 0; m_cvo = 0; m_ph = 0;
  endtask

  // Drive one step at a negedge, advance the model, then wait for the next negedge.
  task automatic step(input logic [3:0] s, input logic a);
    bit dd, qq, d_dio, q_dio;
    longint vl, ir, nil, nvo;
    sw = s; alt_step = a;
    d_dio = !s[0] && !s[2] && (m_il < 0);
    q_dio = !s[1] && !s[3] && (m_il > 0);
    dd = s[0] || d_dio;
    qq = s[1] || q_dio;
    if (dd && !qq)      vl = longint'(vg) - m_vo;   // R4
    else if (!dd && qq) vl = -longint'(vg) - m_vo;  // R5
    else                vl = -m_vo;                 // R6
    nil = sat(m_il + ((vl * longint'(k_il)) >>> CF));          // R7, R9
    ir  = (m_vo * longint'(k_ld)) >>> CF;
    nvo = sat(m_vo + (((m_il - ir) * longint'(k_vo)) >>> CF)); // R8
    if (a) il_tag = "R10";
    else if (d_dio) il_tag = "R2";
    else if (q_dio) il_tag = "R3";
    else if (dd && !qq) il_tag = "R4";
    else if (!dd && qq) il_tag = "R5";
    else il_tag = "R6";
    if (!m_ph) begin
      m_cil = nil; m_cvo = nvo;
      if (!a) begin m_il = nil; m_vo = nvo; end
    end else if (a) begin
      m_il = m_cil; m_vo = m_cvo;
    end else begin
      m_il = nil; m_vo = nvo;
    end
    m_ph = !m_ph;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(1_500_000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 il", longint'(il), 0);
    check("R1 vo", longint'(vo), 0);
    rst = 1'b0;

    // Random gate stream, every step updated
    vg = 32'sd13107200; k_il = 18'd3277; k_vo = 18'd6554; k_ld = 18'd5461;
    for (int i = 0; i < 4000; i++) begin
      step(4'($urandom()), 1'b0);
      check({il_tag, " R7 il"}, longint'(il), m_il);
      check("R8 vo", longint'(vo), m_vo);
    end

    // Two-cycle mode on the same kind of stream
    for (int i = 0; i < 2000; i++) begin
      step(4'($urandom()), 1'b1);
      check("R10 il", longint'(il), m_il);
      check("R10 vo", longint'(vo), m_vo);
    end

    // Reset in the middle of a run, phase restarts at 0
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    model_reset();
    check("R1 il mid", longint'(il), 0);
    check("R1 vo mid", longint'(vo), 0);
    rst = 1'b0;
    for (int i = 0; i < 400; i++) begin
      step(4'($urandom()), 1'b1);
      check("R10 il restart", longint'(il), m_il);
      check("R10 vo restart", longint'(vo), m_vo);
    end

    // Saturation toward the positive rail: upper-left and lower-right on, cfg 10
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    model_reset();
    rst = 1'b0;
    vg = 32'sd1073741824; k_il = 18'h3FFFF; k_vo = '0; k_ld = '0;
    for (int i = 0; i < 10; i++) step(4'b1001, 1'b0);
    check("R9 il pos rail", longint'(il), SMAX);
    check("R9 il pos model", longint'(il), m_il);
    // Toward the negative rail: upper-right and lower-left on, cfg 01
    for (int i = 0; i < 10; i++) step(4'b0110, 1'b0);
    check("R9 il neg rail", longint'(il), SMIN);
    check("R9 vo held", longint'(vo), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule